// File: doc/BRIEF.md
# Synchronizing Two-Wire Bus Clock Generator

This block makes the serial clock for a master on a two-wire bus whose clock line is open-drain and wired-AND. Any other master or slave on the bus may also hold that line low. The block counts a low period and a high period in system clocks. It does not simply run free. It reads the real line level back through a two-flop synchronizer and lines up its own counting with what the bus is actually doing.

The block pulls the line low for its own low period and then lets go. If the line is still low at that point, the block waits. The line can be held low by a master with a longer low period, or by a slave that stretches the clock after a byte. The block starts its high count only when it sees the line go high. If another participant pulls the line low before the block's own high count ends, the block starts a new low period at once. So the bus low time follows the longest low period, and the bus high time follows the shortest high period.

A one-cycle tick marks the start of each high phase, so a data shifter nearby can sample there. Clearing the enable lets go of the line and parks the block.

Top module: `wired_scl_gen`

## Requirements
- R1: While reset is held, or while `en` is low, `scl_pull` is 0 and `rise_tick` is 0.
- R2: With no other participant, each low phase of the line lasts exactly max(`low_period`, 4) system clocks.
- R3: With no other participant, each high phase of the line lasts exactly max(`high_period`, 4) system clocks, counted from the line's rising edge.
- R4: Settings below 4, including 0, behave exactly like 4.
- R5: When another master has a longer low period L2, each bus low phase lasts max(own low, L2) within one cycle.
- R6: When another master has a shorter high period H2, each bus high phase lasts min(own high, H2) within one cycle. After that early fall, the block's next low phase ends at its own low count, measured from the fall.
- R7: While a slave holds the line low, the block releases its pull-down and issues no tick. The bus low phase then lasts as long as the hold, within one cycle.
- R8: `rise_tick` is a single-cycle pulse. It appears exactly 3 system clocks after each rising edge of the line, once per high phase.
- R9: Dropping `en` releases `scl_pull` by the next clock edge.
- R10: A continuous assertion of `scl_pull` never lasts longer than the effective low setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low parks the block with the line released |
| low_period | input | CW | Low-phase length in system clocks (minimum 4) |
| high_period | input | CW | High-phase length in system clocks (minimum 4) |
| scl_in | input | 1 | Level read back from the clock line |
| scl_pull | output | 1 | 1 drives the open-drain clock line low |
| rise_tick | output | 1 | One-cycle pulse at the start of each high count |

## Verification
The bench models a second open-drain master with its own low and high periods. It checks that the bus low time follows the longer low period and the bus high time follows the shorter high period. A design that ran free, or did not restart on an early fall, would shorten the low phases and let high phases drift. A slave stretch of several hundred cycles checks that the pull-down is released and no tick appears. A design that counted through the hold would pull again, or tick while the line was still low. Settings below 4, an enable drop during a low phase, and the fixed 3-cycle offset from the line's rise to the tick catch clamp errors, a late release and a miscounted synchronizer delay.

// File: rtl/wired_scl_gen.sv
module wired_scl_gen #(
  parameter int CW          = 8,
  parameter int MIN_PERIOD  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] low_period,
  input  logic [CW-1:0] high_period,
  input  logic          scl_in,
  output logic          scl_pull,
  output logic          rise_tick
);

  localparam logic [CW-1:0] MINV     = CW'(MIN_PERIOD);
  localparam logic [CW-1:0] SEEN_OFS = CW'(SYNC_STAGES + 1);

  typedef enum logic [1:0] {IDLE, LOW_COUNT, HIGH_WAIT, HIGH_COUNT} st_t;

  st_t                    state;
  logic [CW-1:0]          cnt;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   scl_s;
  logic [CW-1:0]          lo_last, hi_last;

  assign scl_s   = sync_q[SYNC_STAGES-1];
  assign lo_last = ((low_period  < MINV) ? MINV : low_period)  - CW'(1);
  assign hi_last = ((high_period < MINV) ? MINV : high_period) - CW'(1);
  assign scl_pull = (state == LOW_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], scl_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= IDLE;
      cnt       <= '0;
      rise_tick <= 1'b0;
    end else begin
      rise_tick <= 1'b0;
      if (!en) begin
        state <= IDLE;
        cnt   <= '0;
      end else begin
        case (state)
          IDLE: begin
            state <= LOW_COUNT;
            cnt   <= '0;
          end
          LOW_COUNT: begin
            if (cnt >= lo_last) begin
              state <= HIGH_WAIT;
              cnt   <= '0;
            end else cnt <= cnt + CW'(1);
          end
          HIGH_WAIT: begin
            if (scl_s) begin
              state     <= HIGH_COUNT;
              cnt       <= SEEN_OFS;
              rise_tick <= 1'b1;
            end
          end
          HIGH_COUNT: begin
            if (!scl_s) begin
              state <= LOW_COUNT;
              cnt   <= SEEN_OFS;
            end else if (cnt >= hi_last) begin
              state <= LOW_COUNT;
              cnt   <= '0;
            end else cnt <= cnt + CW'(1);
          end
          default: state <= IDLE;
        endcase
      end
    end
  end

  assert_tick_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |=> !rise_tick);

  assert_tick_line_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |-> scl_s);

  assert_disable_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !scl_pull);

  assert_low_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull && en && cnt >= lo_last) |=> !scl_pull);

  assert_wait_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HIGH_WAIT && !scl_s && en) |=> (!scl_pull && !rise_tick));

endmodule

// File: tb/wired_scl_gen_tb_top.sv
module wired_scl_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [7:0] low_p = 8'd10, high_p = 8'd10;
  logic scl_pull, rise_tick, scl_line, hold = 1'b0;

  logic om_en = 1'b0;
  int   om_L = 8, om_H = 8;
  logic [1:0] om_st = 2'd1;
  int   om_cnt = 0;
  logic om_pull;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign om_pull  = om_en && (om_st == 2'd0);
  assign scl_line = ~(scl_pull | om_pull | hold);

  wired_scl_gen dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .low_period(low_p), .high_period(high_p),
    .scl_in(scl_line), .scl_pull(scl_pull), .rise_tick(rise_tick));

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (!rst_n || !om_en) begin
      om_st <= 2'd1; om_cnt <= 0;
    end else case (om_st)
      2'd0: if (om_cnt >= om_L - 1) om_st <= 2'd1; else om_cnt <= om_cnt + 1;
      2'd1: if (scl_line) begin om_st <= 2'd2; om_cnt <= 1; end
      default: if (!scl_line) begin om_st <= 2'd0; om_cnt <= 1; end
               else if (om_cnt >= om_H - 1) begin om_st <= 2'd0; om_cnt <= 0; end
               else om_cnt <= om_cnt + 1;
    endcase
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff(int v);
    return (v < 4) ? 4 : v;
  endfunction

  bit    armed = 0;
  int    skip = 0, phases = 0;
  int    lo_min, lo_max, hi_min, hi_max, cur_effL = 4;
  string tag_lo = "R2", tag_hi = "R3";
  bit    last_line = 1, prev_tick = 0;
  int    run_start = 0, rise_cyc = -100, last_low = 0, pull_run = 0, tick_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_line != last_line) begin
        int len;
        len = cyc - run_start;
        if (last_line) begin
          if (armed && skip == 0) chk(len >= hi_min && len <= hi_max, tag_hi, len, hi_min);
        end else begin
          last_low = len;
          if (armed && skip == 0) chk(len >= lo_min && len <= lo_max, tag_lo, len, lo_min);
        end
        if (skip > 0) skip--;
        phases++;
        run_start = cyc;
        if (scl_line) rise_cyc = cyc;
        last_line = scl_line;
      end
      if (rise_tick) begin
        tick_cnt++;
        if (armed) chk(cyc - rise_cyc == 3, "R8 tick offset", cyc - rise_cyc, 3);
        if (prev_tick) chk(0, "R8 tick width", 2, 1);
      end
      prev_tick = rise_tick;
      if (scl_pull) pull_run++;
      else begin
        if (pull_run > 0 && armed) chk(pull_run <= cur_effL, "R10 pull length", pull_run, cur_effL);
        pull_run = 0;
      end
    end
  end

  task automatic cfg(int l, int h, bit om, int l2, int h2, string tl, string th);
    @(posedge clk); #1 en = 0; om_en = 0; armed = 0;
    repeat (4) @(posedge clk);
    #1 low_p = 8'(l); high_p = 8'(h); om_L = l2; om_H = h2;
    cur_effL = eff(l);
    if (om) begin
      lo_min = ((eff(l) > l2) ? eff(l) : l2) - 1; lo_max = lo_min + 2;
      hi_min = ((eff(h) < h2) ? eff(h) : h2) - 1; hi_max = hi_min + 2;
    end else begin
      lo_min = eff(l); lo_max = eff(l); hi_min = eff(h); hi_max = eff(h);
    end
    tag_lo = tl; tag_hi = th;
    skip = 4; en = 1; om_en = om; armed = 1;
  endtask

  task automatic run_phases(int n);
    int target;
    target = phases + n;
    while (phases < target) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int pc;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!scl_pull && !rise_tick, "R1 in reset", int'(scl_pull), 0);
    @(posedge clk); #1 rst_n = 1;
    pc = 0;
    repeat (20) begin @(negedge clk); if (scl_pull || rise_tick) pc++; end
    chk(pc == 0 && scl_line, "R1 disabled idle", pc, 0);

    cfg(10, 12, 0, 0, 0, "R2 solo low", "R3 solo high"); run_phases(12);
    cfg(1, 0, 0, 0, 0, "R4 clamp low", "R4 clamp high"); run_phases(12);
    cfg(3, 40, 0, 0, 0, "R4 clamp low", "R3 solo high"); run_phases(10);
    for (int i = 0; i < 5; i++) begin
      cfg(int'($urandom_range(0, 50)), int'($urandom_range(0, 50)), 0, 0, 0,
          "R2 rand low", "R3 rand high");
      run_phases(10);
    end

    cfg(8, 20, 1, 25, 9, "R5 long other low", "R6 short other high"); run_phases(12);
    for (int i = 0; i < 4; i++) begin
      int l, h;
      l = int'($urandom_range(4, 30)); h = int'($urandom_range(4, 40));
      cfg(l, h, 1, l + int'($urandom_range(1, 20)), int'($urandom_range(4, 40)),
          "R5 rand other low", "R6 rand other high");
      run_phases(12);
    end

    cfg(6, 8, 0, 0, 0, "R2 solo low", "R3 solo high"); run_phases(6);
    begin
      int t0, s;
      s = 300;
      while (!(last_line == 0 && skip == 0)) @(negedge clk);
      while (last_line != 1) @(negedge clk);
      while (last_line != 0) @(negedge clk);
      @(posedge clk); #1 hold = 1; armed = 0; t0 = tick_cnt;
      repeat (s - 2) @(posedge clk);
      @(negedge clk);
      chk(!scl_pull && !scl_line, "R7 released during hold", int'(scl_pull), 0);
      chk(tick_cnt == t0, "R7 no tick during hold", tick_cnt - t0, 0);
      @(posedge clk); #1 hold = 0;
      run_phases(2);
      chk(last_low >= s - 1 && last_low <= s + 1, "R7 stretched low", last_low, s);
      armed = 1; skip = 1;
      run_phases(6);
    end

    cfg(20, 20, 0, 0, 0, "R2 solo low", "R3 solo high"); run_phases(5);
    while (!scl_pull) @(negedge clk);
    @(posedge clk); #1 en = 0; armed = 0;
    @(posedge clk); @(negedge clk);
    chk(!scl_pull && scl_line, "R9 release on disable", int'(scl_pull), 0);
    pc = 0;
    repeat (10) begin @(negedge clk); if (scl_pull || rise_tick) pc++; end
    chk(pc == 0, "R1 stays idle after disable", pc, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule